// File: doc/BRIEF.md
# Framed Serial Command Interpreter

This block sits at the command input of a linear image sensor front end. A single data line is sampled on every rising clock edge. Commands arrive as framed bytes. Each frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. The interpreter recovers each byte and decodes four opcodes. It turns them into single-cycle strobes for the pixel integrators and for a pixel readout engine. The state of the analog integrators is modelled only as two status levels.

After power-up, the interpreter does not trust its own frame alignment until it has been synchronised. Two events synchronise it. One is a break, which is ten or more consecutive zero samples. The other is three main-reset bytes received in a row. A frame whose stop bit is missing flags a framing error and drops synchronisation. After every stop bit there is a short hold-off during which a falling line is not taken as a new start bit. A start-integration command takes effect only after a fixed settling delay. A main reset can cancel that delay.

Top module: `serial_cmd_interp`

## Requirements
- R1: A frame is a low start bit, then eight data bits with bit 0 first, then a high stop bit. An accepted byte is decoded on the clock edge that samples its stop bit. Any command strobe is high for exactly the one cycle after that edge, and at most one strobe is high at a time.
- R2: On the five clock edges that follow a stop-bit edge, a low input is not taken as a start bit. On the sixth edge, a low input is taken as a start bit.
- R3: Ten consecutive low samples form a break. A break sets `inSync`, does not set `frameErr`, and makes the receiver wait for a high sample before the next start bit. Nine low samples followed by a high stop bit are an ordinary 0x00 byte.
- R4: After reset, and after any framing error, only opcode 0x1B has an effect. The third 0x1B received in a row, with no other byte and no framing error between them, sets `inSync`.
- R5: Opcode 0x1B always acts. It pulses `resetPulse` for one cycle, which aborts the readout. It clears `integrating` and `sampleHeld` and cancels a pending start of integration.
- R6: Opcode 0x08, when synchronised, arms a delayed start. `integrating` goes high on the 22nd clock edge after the decode edge.
- R7: Opcode 0x10, when synchronised, pulses `samplePulse`, sets `sampleHeld` and clears `integrating` on the same edge.
- R8: Opcode 0x02, when synchronised, pulses `readoutStart` for one cycle.
- R9: Any other opcode raises no strobe and changes neither `integrating` nor `sampleHeld`.
- R10: A low sample in the stop-bit position that is not a break discards the byte. It sets `frameErr` and clears `inSync`. `frameErr` stays set until the next byte with a valid stop bit.
- R11: While `rstN` is low, and on leaving reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the data line is sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| sdIn | input | 1 | Serial command line, idle high |
| resetPulse | output | 1 | One-cycle main-reset strobe; also aborts the readout |
| samplePulse | output | 1 | One-cycle strobe to move integrator contents into the hold stage |
| readoutStart | output | 1 | One-cycle strobe that starts the pixel readout engine |
| integrating | output | 1 | Integrators are collecting charge |
| sampleHeld | output | 1 | The hold stage contains a valid sample |
| frameErr | output | 1 | The last frame ended with a missing stop bit |
| inSync | output | 1 | The command interpreter is aligned to byte boundaries |

## Verification
The hardest conditions to reach from the pins are the edge of the post-stop hold-off and a break that lands exactly on the stop-bit position. For the hold-off, the bench starts a complete frame on the last guarded edge. It chooses the byte so that an early accept would decode a read command, while the correct one-cycle-late alignment decodes an unknown opcode. For the break, a 0x00 frame is sent once with a high stop bit and once with a low one. This separates nine zeros from ten. Beyond these cases, all 256 opcodes are swept while synchronised. A bench model tracks the integration and hold state, and the delayed start is timed by counting edges.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_MAIN_RESET = 8'h1B;
  localparam logic [BYTE_W-1:0] OP_START_INT  = 8'h08;
  localparam logic [BYTE_W-1:0] OP_SAMPLE     = 8'h10;
  localparam logic [BYTE_W-1:0] OP_READ       = 8'h02;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_STOP,
    RX_GUARD,
    RX_WAITHIGH
  } rxState_e;

  // control -> datapath
  typedef struct packed {
    logic clrBits;
    logic shiftEn;
    logic armGuard;
    logic armDelay;
    logic dropDelay;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic              lastBit;
    logic              guardDone;
    logic              breakSeen;
    logic              delayDone;
    logic [BYTE_W-1:0] rxByte;
  } dpStatus_t;
endpackage

// File: rtl/sci_datapath.sv
module sci_datapath
  import sci_pkg::*;
#(
  parameter int BREAK_LEN    = 10,
  parameter int GUARD_CYCLES = 5,
  parameter int START_DELAY  = 22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdIn,
  input  ctrlStrobe_t stb,
  output dpStatus_t   st
);
  localparam int ZW = $clog2(BREAK_LEN + 1);
  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam int DW = $clog2(START_DELAY + 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [ZW-1:0] ZERO_SAT  = ZW'(BREAK_LEN);
  localparam logic [ZW-1:0] ZERO_LAST = ZW'(BREAK_LEN - 1);
  localparam logic [GW-1:0] GUARD_LD  = GW'(GUARD_CYCLES - 1);
  localparam logic [DW-1:0] DELAY_LD  = DW'(START_DELAY - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_W - 1);

  logic [ZW-1:0]     zeroRun;
  logic [BW-1:0]     bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [GW-1:0]     guardCnt;
  logic [DW-1:0]     delayCnt;
  logic              delayPend;

  // run of consecutive low samples, saturating so a long break fires once
  always_ff @(posedge clk) begin
    if (!rstN || sdIn)            zeroRun <= '0;
    else if (zeroRun != ZERO_SAT) zeroRun <= zeroRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrBits) bitCnt <= '0;
    else if (stb.shiftEn)     bitCnt <= bitCnt + 1'b1;
  end

  // first data bit ends up in bit 0
  always_ff @(posedge clk) begin
    if (!rstN)            shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {sdIn, shiftReg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                guardCnt <= '0;
    else if (stb.armGuard)    guardCnt <= GUARD_LD;
    else if (guardCnt != '0)  guardCnt <= guardCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.dropDelay) begin
      delayPend <= 1'b0;
      delayCnt  <= '0;
    end else if (stb.armDelay) begin
      delayPend <= 1'b1;
      delayCnt  <= DELAY_LD;
    end else if (delayPend) begin
      if (delayCnt == '0) delayPend <= 1'b0;
      else                delayCnt  <= delayCnt - 1'b1;
    end
  end

  always_comb begin
    st.lastBit   = (bitCnt == BIT_LAST);
    st.guardDone = (guardCnt == '0);
    st.breakSeen = !sdIn && (zeroRun == ZERO_LAST);
    st.delayDone = delayPend && (delayCnt == '0);
    st.rxByte    = shiftReg;
  end
endmodule

// File: rtl/sci_control.sv
module sci_control
  import sci_pkg::*;
#(
  parameter int SYNC_RESETS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdIn,
  input  dpStatus_t   st,
  output ctrlStrobe_t stb,
  output logic        resetPulse,
  output logic        samplePulse,
  output logic        readoutStart,
  output logic        integrating,
  output logic        sampleHeld,
  output logic        frameErr,
  output logic        inSync
);
  localparam int RW = $clog2(SYNC_RESETS + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(SYNC_RESETS - 1);

  rxState_e      state, stateNext;
  logic [RW-1:0] resetRun;
  logic          byteOk, stopBad;
  logic          isReset, isStart, isSample, isRead;

  always_comb begin
    byteOk   = (state == RX_STOP) && sdIn;
    stopBad  = (state == RX_STOP) && !sdIn && !st.breakSeen;
    isReset  = byteOk && (st.rxByte == OP_MAIN_RESET);
    isStart  = byteOk && inSync && (st.rxByte == OP_START_INT);
    isSample = byteOk && inSync && (st.rxByte == OP_SAMPLE);
    isRead   = byteOk && inSync && (st.rxByte == OP_READ);

    stb           = '0;
    stb.clrBits   = (state == RX_IDLE) && !sdIn;
    stb.shiftEn   = (state == RX_DATA);
    stb.armGuard  = byteOk;
    stb.armDelay  = isStart;
    stb.dropDelay = isReset;

    stateNext = state;
    case (state)
      RX_IDLE:     if (!sdIn)      stateNext = RX_DATA;
      RX_DATA:     if (st.lastBit) stateNext = RX_STOP;
      RX_STOP:     stateNext = sdIn ? RX_GUARD : RX_WAITHIGH;
      RX_GUARD:    if (st.guardDone) stateNext = RX_IDLE;
      RX_WAITHIGH: if (sdIn)       stateNext = RX_IDLE;
      default:     stateNext = RX_WAITHIGH;
    endcase
    if (st.breakSeen) stateNext = RX_WAITHIGH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= RX_WAITHIGH;
      resetPulse   <= 1'b0;
      samplePulse  <= 1'b0;
      readoutStart <= 1'b0;
      integrating  <= 1'b0;
      sampleHeld   <= 1'b0;
      frameErr     <= 1'b0;
      inSync       <= 1'b0;
      resetRun     <= '0;
    end else begin
      state        <= stateNext;
      resetPulse   <= isReset;
      samplePulse  <= isSample;
      readoutStart <= isRead;

      if (st.delayDone) integrating <= 1'b1;
      if (isSample) begin
        integrating <= 1'b0;
        sampleHeld  <= 1'b1;
      end
      if (isReset) begin
        integrating <= 1'b0;
        sampleHeld  <= 1'b0;
      end

      if (byteOk)       frameErr <= 1'b0;
      else if (stopBad) frameErr <= 1'b1;

      if (st.breakSeen) begin
        inSync   <= 1'b1;
        resetRun <= '0;
      end else if (stopBad) begin
        inSync   <= 1'b0;
        resetRun <= '0;
      end else if (byteOk) begin
        if (st.rxByte == OP_MAIN_RESET) begin
          if (resetRun == RUN_LAST) inSync   <= 1'b1;
          else                      resetRun <= resetRun + 1'b1;
        end else begin
          resetRun <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_interp.sv
module serial_cmd_interp
  import sci_pkg::*;
#(
  parameter int BREAK_LEN    = 10,
  parameter int GUARD_CYCLES = 5,
  parameter int START_DELAY  = 22,
  parameter int SYNC_RESETS  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdIn,
  output logic resetPulse,
  output logic samplePulse,
  output logic readoutStart,
  output logic integrating,
  output logic sampleHeld,
  output logic frameErr,
  output logic inSync
);
  ctrlStrobe_t strobes;
  dpStatus_t   status;

  sci_datapath #(
    .BREAK_LEN   (BREAK_LEN),
    .GUARD_CYCLES(GUARD_CYCLES),
    .START_DELAY (START_DELAY)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .sdIn(sdIn),
    .stb (strobes),
    .st  (status)
  );

  sci_control #(
    .SYNC_RESETS(SYNC_RESETS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sdIn        (sdIn),
    .st          (status),
    .stb         (strobes),
    .resetPulse  (resetPulse),
    .samplePulse (samplePulse),
    .readoutStart(readoutStart),
    .integrating (integrating),
    .sampleHeld  (sampleHeld),
    .frameErr    (frameErr),
    .inSync      (inSync)
  );
endmodule

// File: rtl/sci_checker.sv
module sci_checker #(
  parameter int START_DELAY = 22
) (
  input logic clk,
  input logic rstN,
  input logic resetPulse,
  input logic samplePulse,
  input logic readoutStart,
  input logic integrating,
  input logic sampleHeld,
  input logic frameErr,
  input logic inSync,
  input logic armDelay
);
  localparam int AW = $clog2(START_DELAY + 2);
  localparam logic [AW-1:0] AGE_SAT = AW'(START_DELAY + 1);

  // edges elapsed since the delayed start was last armed
  logic [AW-1:0] armAge;
  always_ff @(posedge clk) begin
    if (!rstN)                armAge <= AGE_SAT;
    else if (armDelay)        armAge <= '0;
    else if (armAge != AGE_SAT) armAge <= armAge + 1'b1;
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, samplePulse, readoutStart})); // R1
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse); // R5
  AST_RESET_CLEARS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> (!integrating && !sampleHeld)); // R5
  AST_CMD_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (samplePulse || readoutStart) |-> inSync); // R4
  AST_INT_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(integrating) |-> (armAge == AW'(START_DELAY))); // R6
  AST_SAMPLE_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> (sampleHeld && !integrating)); // R7
  AST_HELD_ONLY_BY_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleHeld) |-> samplePulse); // R7
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    readoutStart |=> !readoutStart); // R8
  AST_FRAMEERR_UNSYNCS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !inSync); // R10
endmodule

bind serial_cmd_interp sci_checker #(
  .START_DELAY(START_DELAY)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetPulse  (resetPulse),
  .samplePulse (samplePulse),
  .readoutStart(readoutStart),
  .integrating (integrating),
  .sampleHeld  (sampleHeld),
  .frameErr    (frameErr),
  .inSync      (inSync),
  .armDelay    (strobes.armDelay)
);

// File: tb/serial_cmd_interp_tb.sv
module serial_cmd_interp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdIn = 1'b1;
  logic resetPulse, samplePulse, readoutStart;
  logic integrating, sampleHeld, frameErr, inSync;

  int nChk = 0;
  int nFail = 0;
  int edgeCnt = 0;
  int cntRead = 0;
  bit finished = 1'b0;
  logic capRst, capSamp, capRead;
  int decodeEdge;

  always #10 clk = ~clk;  // 50 MHz

  serial_cmd_interp u_dut (
    .clk(clk), .rstN(rstN), .sdIn(sdIn),
    .resetPulse(resetPulse), .samplePulse(samplePulse),
    .readoutStart(readoutStart), .integrating(integrating),
    .sampleHeld(sampleHeld), .frameErr(frameErr), .inSync(inSync)
  );

  always @(posedge clk) edgeCnt++;
  always @(negedge clk) if (rstN && readoutStart) cntRead++;

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives start, 8 data bits (bit 0 first) and stop; returns one cycle after the stop edge
  task automatic sendFrame(input logic [7:0] b, input logic stopBit);
    @(negedge clk) sdIn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sdIn = b[i];
    end
    @(negedge clk) sdIn = stopBit;
    @(negedge clk);
    capRst = resetPulse; capSamp = samplePulse; capRead = readoutStart;
    decodeEdge = edgeCnt;
    sdIn = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] b);
    sendFrame(b, 1'b1);
    idle(4);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int snap;
    int expInt, expHeld, pendAt;
    idle(3);
    chk("R11 resetPulse in reset", resetPulse, 0);
    chk("R11 inSync in reset", inSync, 0);
    rstN = 1'b1;
    idle(1);
    chk("R11 outputs after reset", {resetPulse, samplePulse, readoutStart,
        integrating, sampleHeld, frameErr, inSync}, 0);
    idle(2);

    // unsynchronised: only main reset acts
    sendCmd(8'h10);
    chk("R4 sample ignored unsynced", capSamp, 0);
    chk("R4 held unchanged unsynced", sampleHeld, 0);
    sendCmd(8'h02);
    chk("R4 read ignored unsynced", capRead, 0);
    sendCmd(8'h1B);
    chk("R5 reset acts unsynced", capRst, 1);
    chk("R4 sync after one reset", inSync, 0);
    sendCmd(8'h1B);
    chk("R4 sync after two resets", inSync, 0);
    sendCmd(8'h1B);
    chk("R4 sync after three resets", inSync, 1);

    // delayed start of integration
    sendFrame(8'h08, 1'b1);
    chk("R9 start raises no strobe", {capRst, capSamp, capRead}, 0);
    while (edgeCnt < decodeEdge + 21) @(negedge clk);
    chk("R6 integrating at edge 21", integrating, 0);
    @(negedge clk);
    chk("R6 integrating at edge 22", integrating, 1);
    idle(2);

    sendCmd(8'h10);
    chk("R7 sample strobe", capSamp, 1);
    chk("R7 sample held", sampleHeld, 1);
    chk("R7 integrating cleared", integrating, 0);

    sendCmd(8'h02);
    chk("R8 read strobe", capRead, 1);

    // main reset cancels a pending start
    sendCmd(8'h08);
    sendCmd(8'h1B);
    chk("R5 reset strobe", capRst, 1);
    chk("R5 held cleared", sampleHeld, 0);
    idle(30);
    chk("R5 pending start cancelled", integrating, 0);

    // hold-off: a frame starting on the fifth guarded edge must not decode as 0x02
    sendFrame(8'h02, 1'b1);
    idle(3);
    snap = cntRead;
    sendFrame(8'h02, 1'b1);
    idle(15);
    chk("R2 start in guard ignored", cntRead - snap, 0);
    chk("R2 no framing error", frameErr, 0);
    sendFrame(8'h02, 1'b1);
    idle(4);
    sendFrame(8'h02, 1'b1);
    chk("R2 start on sixth edge accepted", capRead, 1);
    idle(4);

    // exhaustive opcode sweep with a bench model of integration and hold state
    expInt = 0; expHeld = 0; pendAt = -1;
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b1);
      if (pendAt >= 0 && decodeEdge >= pendAt) begin
        expInt = 1; pendAt = -1;
      end
      if (b == 8'h1B) begin expInt = 0; expHeld = 0; pendAt = -1; end
      if (b == 8'h10) begin expInt = 0; expHeld = 1; end
      if (b == 8'h08) pendAt = decodeEdge + 22;
      chk($sformatf("R5 reset strobe op %0d", b), capRst, (b == 8'h1B) ? 1 : 0);
      chk($sformatf("R1 sample strobe op %0d", b), capSamp, (b == 8'h10) ? 1 : 0);
      chk($sformatf("R8 read strobe op %0d", b), capRead, (b == 8'h02) ? 1 : 0);
      chk($sformatf("R9 integrating op %0d", b), integrating, expInt);
      chk($sformatf("R9 held op %0d", b), sampleHeld, expHeld);
      idle(4);
    end

    // missing stop bit
    sendFrame(8'h02, 1'b0);
    chk("R10 byte discarded", capRead, 0);
    chk("R10 frame error set", frameErr, 1);
    chk("R10 sync dropped", inSync, 0);
    idle(2);

    // nine zeros are a byte, ten are a break
    sendFrame(8'h00, 1'b1);
    chk("R3 nine zeros no sync", inSync, 0);
    chk("R10 frame error cleared by valid byte", frameErr, 0);
    idle(4);
    sendFrame(8'h00, 1'b0);
    chk("R3 ten zeros sync", inSync, 1);
    chk("R3 break not a framing error", frameErr, 0);
    idle(3);
    sendCmd(8'h02);
    chk("R3 receiver recovers after break", capRead, 1);

    // long break after a framing error
    sendFrame(8'h10, 1'b0);
    chk("R10 sync dropped again", inSync, 0);
    idle(2);
    @(negedge clk) sdIn = 1'b0;
    idle(13);
    @(negedge clk) sdIn = 1'b1;
    idle(2);
    chk("R3 long break sync", inSync, 1);
    chk("R10 frame error held over break", frameErr, 1);
    sendCmd(8'h10);
    chk("R7 sample after long break", capSamp, 1);
    chk("R10 frame error cleared", frameErr, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule